// File: doc/BRIEF.md
# Two-World System Control Register

This block holds the 32-bit system control word that a processor core uses to configure alignment checking, endianness, memory translation, caches, branch prediction, the exception vector location and interrupt latency. The block serves two security worlds. Most functional bits are banked, so the secure and the non-secure world each have a private copy. A small group of bits is owned by the secure world: a single copy exists, both worlds can read it, and only the secure world can change it.

Software reaches the register through a coprocessor-style port. The port carries read and write strobes, the requester's privilege level and world, write data and read data. It also returns an undefined-instruction flag for accesses that are refused. A lockout input can block secure writes. Three strap inputs set the reset values of the vector-location bit and of the endianness and unaligned-access bits. The block drives the view of the control bits for the core's current world to the rest of the core at all times.

Top module: `sysctl_dual_world`

## Requirements
- R1: A read or write with `acc_priv` low raises `acc_undef` in the same cycle and changes no stored bit in either world.
- R2: A privileged secure write (`acc_ns` low) while `sec_wr_lock` is high raises `acc_undef` and leaves every stored bit unchanged.
- R3: A privileged secure write with `sec_wr_lock` low loads the banked bits of `acc_wdata` into the secure copy and loads bits 21, 15, 14 and 7 into the secure-owned copy. It does so on the next rising clock edge and raises no `acc_undef`.
- R4: A privileged non-secure write loads the banked bits into the non-secure copy only. It leaves the secure copy and the secure-owned bits 21, 15, 14 and 7 unchanged, and it raises no `acc_undef`.
- R5: Bits 21, 15, 14 and 7 read back the single secure-owned copy, whichever world reads them.
- R6: The banked bits are 29, 28, 25, 24, 23, 22, 13, 12, 11, 9, 8, 2, 1 and 0. A privileged read returns the copy of the world that `acc_ns` names.
- R7: Bits 18, 16 and 6 to 3 always read as one. All other unlisted bits (31:30, 27:26, 20:19, 17, 10) always read as zero. Writes to any of these bits have no effect.
- R8: After reset every functional bit is zero in both copies, with four exceptions. Bit 13 equals `strap_hivec`, bit 7 equals `strap_bigend`, and bit 22 equals `strap_unalign`. Bit 25 is one only when both `strap_bigend` and `strap_unalign` are high. Banked bits take the same value in both copies.
- R9: `ctl_view` always shows the word a privileged read would return from the world named by `core_ns`.
- R10: `acc_rdata` is zero unless `acc_rd` and `acc_priv` are both high. It is combinational from the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_hivec | input | 1 | Reset value of the vector-location bit |
| strap_bigend | input | 1 | Endian strap used at reset |
| strap_unalign | input | 1 | Unaligned-access strap used at reset |
| sec_wr_lock | input | 1 | Blocks secure writes when high |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_priv | input | 1 | Requester is privileged |
| acc_ns | input | 1 | Requester is in the non-secure world |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data |
| acc_undef | output | 1 | Access refused, raise undefined instruction |
| core_ns | input | 1 | Core's current world, selects `ctl_view` |
| ctl_view | output | 32 | Effective control bits for the current world |

## Verification
A corrupted copy inside the block shows up at the ports after at most one access. `ctl_view` shows it at once for the current world. A privileged read from the other world exposes the other copy in the same cycle. A write that leaks into the wrong copy, or into the secure-owned bits, is seen on the first read after the write edge. The bench reads both worlds after every access in the mode sweep, so no leak goes unseen longer than one access. A wrong refusal decision is visible on `acc_undef` in the cycle of the access.

// File: rtl/sysctl_dual_world.sv
module sysctl_dual_world #(
  parameter int W = 32,
  parameter logic [W-1:0] BANK_MASK = 32'h33C0_3B07,
  parameter logic [W-1:0] SOWN_MASK = 32'h0020_C080,
  parameter logic [W-1:0] ONES_MASK = 32'h0005_0078,
  parameter int HIVEC_BIT  = 13,
  parameter int BIGEND_BIT = 7,
  parameter int UNAL_BIT   = 22,
  parameter int EXEND_BIT  = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strap_hivec,
  input  logic         strap_bigend,
  input  logic         strap_unalign,
  input  logic         sec_wr_lock,
  input  logic         acc_rd,
  input  logic         acc_wr,
  input  logic         acc_priv,
  input  logic         acc_ns,
  input  logic [W-1:0] acc_wdata,
  output logic [W-1:0] acc_rdata,
  output logic         acc_undef,
  input  logic         core_ns,
  output logic [W-1:0] ctl_view
);

  logic [W-1:0] bank_s, bank_ns, sown, strap_word;
  logic [W-1:0] view_s, view_ns;
  logic         rd_ok, wr_ok;

  always_comb begin
    strap_word = '0;
    strap_word[HIVEC_BIT]  = strap_hivec;
    strap_word[BIGEND_BIT] = strap_bigend;
    strap_word[UNAL_BIT]   = strap_unalign;
    strap_word[EXEND_BIT]  = strap_bigend & strap_unalign;
  end

  assign rd_ok     = acc_rd & acc_priv;
  assign wr_ok     = acc_wr & acc_priv & (acc_ns | ~sec_wr_lock);
  assign acc_undef = ((acc_rd | acc_wr) & ~acc_priv)
                   | (acc_wr & acc_priv & ~acc_ns & sec_wr_lock);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_s  <= strap_word & BANK_MASK;
      bank_ns <= strap_word & BANK_MASK;
      sown    <= strap_word & SOWN_MASK;
    end else if (wr_ok) begin
      if (acc_ns) begin
        bank_ns <= acc_wdata & BANK_MASK;
      end else begin
        bank_s <= acc_wdata & BANK_MASK;
        sown   <= acc_wdata & SOWN_MASK;
      end
    end
  end

  assign view_s    = (bank_s  & BANK_MASK) | (sown & SOWN_MASK) | ONES_MASK;
  assign view_ns   = (bank_ns & BANK_MASK) | (sown & SOWN_MASK) | ONES_MASK;
  assign acc_rdata = rd_ok ? (acc_ns ? view_ns : view_s) : '0;
  assign ctl_view  = core_ns ? view_ns : view_s;

  assert_user_undef_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_rd || acc_wr) && !acc_priv) |-> acc_undef);
  assert_user_nochange_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_rd || acc_wr) && !acc_priv) |=> ($stable(bank_s) && $stable(bank_ns) && $stable(sown)));
  assert_lock_nochange_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_priv && !acc_ns && sec_wr_lock) |=> ($stable(bank_s) && $stable(bank_ns) && $stable(sown)));
  assert_sec_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_priv && !acc_ns && !sec_wr_lock) |=>
      (bank_s == ($past(acc_wdata) & BANK_MASK)) && (sown == ($past(acc_wdata) & SOWN_MASK)));
  assert_ns_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_priv && acc_ns) |=> ($stable(sown) && $stable(bank_s)));
  assert_sown_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_priv) |-> ((acc_rdata & SOWN_MASK) == (ctl_view & SOWN_MASK)));
  assert_fixed_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_priv) |-> ((acc_rdata & ~(BANK_MASK | SOWN_MASK)) == ONES_MASK));
  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_rd && acc_priv) |-> (acc_rdata == '0));

endmodule

// File: tb/sysctl_dual_world_tb_top.sv
module sysctl_dual_world_tb_top;
  localparam logic [31:0] BANK = 32'h33C0_3B07;
  localparam logic [31:0] SOWN = 32'h0020_C080;
  localparam logic [31:0] ONES = 32'h0005_0078;

  logic clk = 0, rst_n = 0;
  logic strap_hivec = 0, strap_bigend = 0, strap_unalign = 0, sec_wr_lock = 0;
  logic acc_rd = 0, acc_wr = 0, acc_priv = 0, acc_ns = 0, core_ns = 0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata, ctl_view;
  logic acc_undef;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_s, m_ns, m_own;

  always #10 clk = ~clk;

  sysctl_dual_world dut_i (
    .clk(clk), .rst_n(rst_n), .strap_hivec(strap_hivec), .strap_bigend(strap_bigend),
    .strap_unalign(strap_unalign), .sec_wr_lock(sec_wr_lock), .acc_rd(acc_rd),
    .acc_wr(acc_wr), .acc_priv(acc_priv), .acc_ns(acc_ns), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_undef(acc_undef), .core_ns(core_ns), .ctl_view(ctl_view));

  function automatic logic [31:0] exp_view(input logic ns);
    return ((ns ? m_ns : m_s) & BANK) | (m_own & SOWN) | ONES;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic do_reset(input logic hv, input logic be, input logic ua);
    logic [31:0] sw;
    @(negedge clk);
    rst_n = 0; strap_hivec = hv; strap_bigend = be; strap_unalign = ua;
    acc_rd = 0; acc_wr = 0;
    @(negedge clk);
    rst_n = 1;
    sw = '0; sw[13] = hv; sw[7] = be; sw[22] = ua; sw[25] = be & ua;
    m_s = sw & BANK; m_ns = sw & BANK; m_own = sw & SOWN;
  endtask

  task automatic access(input logic rd, input logic wr, input logic priv,
                        input logic ns, input logic lock, input logic [31:0] d,
                        input string req);
    logic eu;
    @(negedge clk);
    acc_rd = rd; acc_wr = wr; acc_priv = priv; acc_ns = ns; sec_wr_lock = lock; acc_wdata = d;
    #1;
    eu = ((rd | wr) & ~priv) | (wr & priv & ~ns & lock);
    chk({req, " undef"}, {31'b0, acc_undef}, {31'b0, eu});
    chk({req, " rdata R10"}, acc_rdata, (rd & priv) ? exp_view(ns) : 32'h0);
    @(posedge clk);
    #1;
    if (wr && priv && (ns || !lock)) begin
      if (ns) m_ns = d & BANK;
      else begin m_s = d & BANK; m_own = d & SOWN; end
    end
    acc_rd = 0; acc_wr = 0; sec_wr_lock = 0;
  endtask

  task automatic read_both(input string req);
    access(1, 0, 1, 0, 0, 32'h0, {req, " R6 sec"});
    access(1, 0, 1, 1, 0, 32'h0, {req, " R5 ns"});
    @(negedge clk);
    core_ns = 0; #1 chk({req, " R9 view sec"}, ctl_view, exp_view(0));
    core_ns = 1; #1 chk({req, " R9 view ns"}, ctl_view, exp_view(1));
  endtask

  initial begin
    #(20 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int s = 0; s < 8; s++) begin
      do_reset(s[0], s[1], s[2]);
      read_both("R8 reset");
    end

    for (int b = 0; b < 32; b++) begin
      access(0, 1, 1, 0, 0, 32'h1 << b, "R3 walk sec");
      read_both("R3 R7 walk sec");
      access(0, 1, 1, 1, 0, ~(32'h1 << b), "R4 walk ns");
      read_both("R4 R7 walk ns");
    end

    do_reset(0, 0, 0);
    for (int m = 0; m < 32; m++) begin
      access(m[0], m[1], m[2], m[3], m[4], 32'hFFFF_FFFF ^ (32'h0904_1103 * m),
             "R1 R2 R3 R4 sweep");
      read_both("R1 R2 sweep readback");
    end

    access(0, 1, 1, 0, 0, 32'hFFFF_FFFF, "R3 all ones");
    access(0, 1, 1, 0, 1, 32'h0, "R2 locked clear");
    read_both("R2 after lock");
    access(0, 1, 1, 1, 1, 32'h0, "R4 ns ignores lock");
    read_both("R4 R5 ns cleared");
    access(0, 1, 0, 0, 0, 32'h0, "R1 user sec write");
    read_both("R1 after user write");
    finish_run();
  end
endmodule